// File: doc/BRIEF.md
# Interrupt Status and Mask Register Unit

This unit collects interrupt sources for a two-wire bus controller into one status word. There are two kinds of source. Seven FIFO condition flags are level signals, and the status word shows them directly. Event sources each give a one-cycle pulse, and the unit latches that pulse in a sticky bit. A host reads and writes four word registers through a simple port: a mask, the raw status, the masked status and a write-one-to-clear register.

The word has a fixed sparse layout. Only the defined positions can ever be one. The top three bits always read as zero. The clear register acts only on its permitted pattern. A level flag cannot be cleared by a write, because it follows its source. A latched event is removed only when the host writes a one to its position. The masked status is the raw status ANDed with the mask. The single interrupt line is the registered OR of the masked status, so it changes one clock after the masked status changes.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the mask register, every latched event bit and the interrupt output are zero.
- R2: Raw bits 6..0 follow the fifo_lvl input with no delay. The level flags in positions 0..6 are: tx empty, tx nearly empty, tx full, tx overrun, rx empty, rx nearly full, rx full. A write to the clear register does not change these bits.
- R3: A one-cycle pulse on evt_set at one of positions 16, 17, 18, 19, 20, 24, 25 or 28 sets that raw bit at the next clock edge. The bit stays set until it is cleared. The events in these positions are: read request from the remote, read-empty from the remote, write request, master done, slave done, arbitration lost, bus error (an unexpected start or stop during a transfer), and master done without stop.
- R4: A pulse on evt_set at any other position, namely 7..15, 21..23, 26, 27 or 29..31, never sets a raw bit.
- R5: Writing to the clear register (address 3) clears, at the next edge, each latched event bit whose wdata bit is one. Event bits whose wdata bit is zero keep their value. If a set pulse and a clear hit the same bit in the same cycle, the bit is set.
- R6: The mask register (address 0) can be written and read back. Its bits 31..29 always read as zero.
- R7: Reading the masked status (address 2) returns the raw status (address 1) ANDed with the mask.
- R8: The irq output equals the OR of all masked status bits from the previous cycle.
- R9: Raw and masked status bits 31..29 are always zero. The clear register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 mask, 1 raw, 2 masked, 3 clear |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| fifo_lvl | input | 7 | Live FIFO condition flags, placed in raw bits 6..0 |
| evt_set | input | 32 | Per-bit single-cycle event set pulses |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the unit with its default 32-bit map. At this width every bit position can be swept one at a time, so each defined event bit and each reserved position is pulsed, read back raw and masked, and cleared on its own. The seven level flags are small enough to cover all 128 combinations, each followed by a clear write to those positions. Directed cases cover a set and a clear on the same bit in the same cycle, a partial clear, and the interrupt output with the mask fully open and fully closed.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int          LVL_W    = 7,
  parameter logic [31:0] EVT_MAP  = 32'h131F_0000,
  parameter logic [31:0] CLR_MAP  = 32'h131F_007F,
  parameter int          RSV_N    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [LVL_W-1:0] fifo_lvl,
  input  logic [31:0] evt_set,
  output logic        irq
);
  localparam logic [31:0] KEEP = {{RSV_N{1'b0}}, {(32-RSV_N){1'b1}}};
  localparam logic [31:0] EVT_OK = EVT_MAP & KEEP;
  localparam logic [1:0] A_MASK = 2'd0, A_RAW = 2'd1, A_MSK = 2'd2, A_CLR = 2'd3;

  logic [31:0] evt_q, mask_q, raw, masked, clr_vec, set_vec;

  assign set_vec = evt_set & EVT_OK;
  assign clr_vec = (wr_en && addr == A_CLR) ? (wdata & CLR_MAP & EVT_OK) : 32'd0;
  assign raw     = (evt_q | 32'(fifo_lvl)) & KEEP;
  assign masked  = raw & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q  <= '0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      evt_q <= (evt_q & ~clr_vec) | set_vec;
      if (wr_en && addr == A_MASK) mask_q <= wdata & KEEP;
      irq <= |masked;
    end
  end

  always_comb begin
    case (addr)
      A_MASK:  rdata = mask_q;
      A_RAW:   rdata = raw;
      A_MSK:   rdata = masked;
      default: rdata = 32'd0;
    endcase
  end

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 0) |=> ((evt_q & $past(set_vec)) == $past(set_vec)));

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_CLR) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R4
  no_stray_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q & ~EVT_OK) == 32'd0);

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|masked)));

  // R9
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw[31:29] == 3'd0) && (mask_q[31:29] == 3'd0));
endmodule

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
  localparam int T = 10;
  localparam logic [31:0] EV = 32'h131F_0000;

  logic clk = 0, rst_n = 0, wr_en = 0, irq;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata, evt_set = 0;
  logic [6:0] fifo_lvl = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  irq_status_unit dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .fifo_lvl(fifo_lvl), .evt_set(evt_set), .irq(irq));

  always #(T/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(logic [31:0] v);
    @(negedge clk); evt_set = v;
    @(negedge clk); evt_set = 0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, d); chk("R1 mask", d, 0);
    rd(1, d); chk("R1 raw", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R6 mask readback", d, 32'h1FFF_FFFF);
    rd(3, d); chk("R9 clear reads zero", d, 0);

    for (int b = 0; b < 32; b++) begin
      logic [31:0] e;
      e = EV & (32'd1 << b);
      pulse(32'd1 << b);
      rd(1, d); chk($sformatf("R3/R4 raw bit %0d", b), d, e);
      rd(2, d); chk($sformatf("R7 masked bit %0d", b), d, e);
      @(negedge clk);
      chk($sformatf("R8 irq bit %0d", b), {31'd0, irq}, {31'd0, e != 0});
      wr(3, 32'd1 << b);
      rd(1, d); chk($sformatf("R5 cleared bit %0d", b), d, 0);
      @(negedge clk);
      chk($sformatf("R8 irq drop bit %0d", b), {31'd0, irq}, 0);
    end

    for (int v = 0; v < 128; v++) begin
      fifo_lvl = 7'(v);
      rd(1, d); chk("R2 level", d, 32'(v));
      wr(3, 32'h7F);
      rd(1, d); chk("R2 clear ignored", d, 32'(v));
    end
    fifo_lvl = 0;

    pulse(32'hFFFF_FFFF);
    rd(1, d); chk("R4 all pulses", d, EV);
    rd(1, d); chk("R9 raw top bits", {29'd0, d[31:29]}, 0);
    wr(3, 32'h0001_0000);
    rd(1, d); chk("R5 partial clear", d, EV & ~32'h0001_0000);

    @(negedge clk); evt_set = 32'h0010_0000; wr_en = 1; addr = 3; wdata = 32'h1FFF_FFFF;
    @(negedge clk); evt_set = 0; wr_en = 0; wdata = 0;
    rd(1, d); chk("R5 set wins", d, 32'h0010_0000);

    wr(0, 32'h0000_0000);
    rd(2, d); chk("R7 masked closed", d, 0);
    @(negedge clk);
    chk("R8 irq masked off", {31'd0, irq}, 0);
    wr(0, 32'h0010_0040);
    fifo_lvl = 7'h40;
    rd(2, d); chk("R7 mixed mask", d, 32'h0010_0040);
    @(negedge clk);
    chk("R8 irq mixed", {31'd0, irq}, 1);

    rst_n = 0; @(negedge clk); rst_n = 1; fifo_lvl = 0;
    rd(0, d); chk("R1 mask after reset", d, 0);
    rd(1, d); chk("R1 raw after reset", d, 0);
    chk("R1 irq after reset", {31'd0, irq}, 0);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule